// File: doc/BRIEF.md
# Serial Offset Register Loader

This block fills the two 9-bit threshold offsets that a FIFO's almost-full and almost-empty flag logic compares against. Software, or a board-level controller, chooses how the offsets are set by the levels it holds on two mode inputs during reset. When both inputs are high in the last reset cycle, the block enters serial mode. It then accepts one bit per write-clock edge while the active-low serial strobe is asserted, until it has taken 18 bits.

The 18-bit stream fills the two offsets as one chain. The first bit lands in the most significant bit of the Y offset. Y's bits come first, then X's, each most significant bit first, so the last bit lands in the least significant bit of X. The input-ready output stays low until the chain is complete, so no FIFO write can happen against half-programmed thresholds. If either mode input is low during reset, both offsets keep a default of 8 and the block reports ready straight away.

Software must send values from 1 to 508 for each offset. The block stores whatever bits arrive and does not check that range.

Top module: `serial_offset_loader`

## Requirements
- R1: While `rst` is high, and on the first clock after a cycle in which it was high, `in_ready` and `prog_done` are 0 and both `x_ofs` and `y_ofs` hold 8.
- R2: Serial mode is entered only when `ser_data` = 1 and `ser_en_n` = 1 in the last clock cycle with `rst` high. Any other combination selects default mode.
- R3: In serial mode, before completion, a bit is taken from `ser_data` on each rising clock edge with `ser_en_n` = 0. An edge with `ser_en_n` = 1 leaves both offsets unchanged.
- R4: Each taken bit shifts the 18-bit concatenation {`y_ofs`,`x_ofs`} left by one place, with the new bit entering at `x_ofs[0]`. After 18 bits, the first bit sits in `y_ofs[8]` and the last in `x_ofs[0]`.
- R5: `prog_done` rises on the edge that takes the 18th bit and stays high until reset.
- R6: In serial mode, `in_ready` stays 0 until the clock edge after the one that takes the 18th bit, and rises on that edge.
- R7: After 18 bits, further edges with `ser_en_n` = 0 leave both offsets unchanged, whatever `ser_data` carries.
- R8: In default mode, the first clock edge with `rst` low raises both `in_ready` and `prog_done`. Both offsets stay at 8, and serial strobes have no effect.
- R9: Asserting `rst` part way through a serial sequence discards the partial chain. After that reset, the mode is selected afresh and a new 18-bit sequence starts from bit zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_data | input | 1 | Serial data bit; also a mode input during reset |
| ser_en_n | input | 1 | Serial strobe, active low; also a mode input during reset |
| x_ofs | output | 9 | X offset register |
| y_ofs | output | 9 | Y offset register |
| in_ready | output | 1 | FIFO input-ready, held low until the offsets are final |
| prog_done | output | 1 | Offsets are final |

## Verification
The hardest cases to reach from the ports are the edges of the 18-bit window. One is a strobe that arrives just after the final bit and must be dropped. Another is a reset that lands partway through the chain. A third is the one-cycle gap between `prog_done` and `in_ready`. To reach them, the stimulus mixes idle cycles into the stream, carrying inverted data that must not be taken. It sends extra strobes with changing data after completion. It also aborts one sequence after seven bits and then loads new boundary values (1 and 508) in both orders. A scoreboard predicts all four outputs on every clock edge, so each of these moments is compared cycle by cycle.

// File: rtl/sol_pkg.sv
package sol_pkg;
  typedef enum logic {
    MODE_DEFAULT = 1'b0,
    MODE_SERIAL  = 1'b1
  } load_mode_e;
endpackage

// File: rtl/sol_mode_sel.sv
module sol_mode_sel
  import sol_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ser_data,
  input  logic       ser_en_n,
  output load_mode_e mode
);
  // Sampled on every reset cycle; the last reset cycle's value is kept.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= (ser_data && ser_en_n) ? MODE_SERIAL : MODE_DEFAULT;
    end
  end
endmodule

// File: rtl/sol_bit_count.sv
module sol_bit_count #(
  parameter int TOTAL_BITS = 18,
  localparam int CNT_W     = $clog2(TOTAL_BITS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic seq_full,
  output logic last_take
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (take) begin
      count_q <= count_q + CNT_W'(1);
    end
  end

  assign seq_full  = (count_q == CNT_W'(TOTAL_BITS));
  assign last_take = take && (count_q == CNT_W'(TOTAL_BITS - 1));
endmodule

// File: rtl/sol_shift_chain.sv
module sol_shift_chain #(
  parameter int OFS_W       = 9,
  parameter int DEFAULT_OFS = 8,
  localparam int CHAIN_W    = 2 * OFS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  logic               bit_in,
  output logic [CHAIN_W-1:0] chain
);
  localparam logic [OFS_W-1:0] DEF = OFS_W'(DEFAULT_OFS);

  always_ff @(posedge clk) begin
    if (rst) begin
      chain[0] <= DEF[0];
    end else if (take) begin
      chain[0] <= bit_in;
    end
  end

  for (genvar i = 1; i < CHAIN_W; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        chain[i] <= DEF[i % OFS_W];
      end else if (take) begin
        chain[i] <= chain[i-1];
      end
    end
  end
endmodule

// File: rtl/sol_ready_ctl.sv
module sol_ready_ctl
  import sol_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  load_mode_e mode,
  input  logic       last_take,
  output logic       in_ready,
  output logic       prog_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prog_done <= 1'b0;
      in_ready  <= 1'b0;
    end else begin
      prog_done <= (mode == MODE_DEFAULT) || last_take || prog_done;
      in_ready  <= (mode == MODE_DEFAULT) || prog_done;
    end
  end
endmodule

// File: rtl/serial_offset_loader.sv
module serial_offset_loader
  import sol_pkg::*;
#(
  parameter int OFS_W       = 9,
  parameter int DEFAULT_OFS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_data,
  input  logic             ser_en_n,
  output logic [OFS_W-1:0] x_ofs,
  output logic [OFS_W-1:0] y_ofs,
  output logic             in_ready,
  output logic             prog_done
);
  localparam int TOTAL_BITS = 2 * OFS_W;

  load_mode_e              mode;
  logic                    seq_full;
  logic                    last_take;
  logic                    take;
  logic [TOTAL_BITS-1:0]   chain;

  assign take = (mode == MODE_SERIAL) && !ser_en_n && !seq_full;

  sol_mode_sel u_mode (
    .clk      (clk),
    .rst      (rst),
    .ser_data (ser_data),
    .ser_en_n (ser_en_n),
    .mode     (mode)
  );

  sol_bit_count #(.TOTAL_BITS(TOTAL_BITS)) u_count (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .seq_full  (seq_full),
    .last_take (last_take)
  );

  sol_shift_chain #(.OFS_W(OFS_W), .DEFAULT_OFS(DEFAULT_OFS)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .bit_in (ser_data),
    .chain  (chain)
  );

  sol_ready_ctl u_ready (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .last_take (last_take),
    .in_ready  (in_ready),
    .prog_done (prog_done)
  );

  assign y_ofs = chain[TOTAL_BITS-1:OFS_W];
  assign x_ofs = chain[OFS_W-1:0];
endmodule

// File: rtl/serial_offset_loader_chk.sv
module serial_offset_loader_chk #(
  parameter int OFS_W       = 9,
  parameter int DEFAULT_OFS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ser_data,
  input logic             ser_en_n,
  input logic [OFS_W-1:0] x_ofs,
  input logic [OFS_W-1:0] y_ofs,
  input logic             in_ready,
  input logic             prog_done
);
  localparam int TOTAL_BITS = 2 * OFS_W;
  localparam int CNT_W      = $clog2(TOTAL_BITS + 1);
  localparam logic [OFS_W-1:0] DEF = OFS_W'(DEFAULT_OFS);

  logic             serial_c;
  logic [CNT_W-1:0] taken_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      serial_c <= ser_data && ser_en_n;
      taken_c  <= '0;
    end else if (serial_c && !ser_en_n && taken_c != CNT_W'(TOTAL_BITS)) begin
      taken_c  <= taken_c + CNT_W'(1);
    end
  end

  // R1
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!in_ready && !prog_done && x_ofs == DEF && y_ofs == DEF));

  // R3
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ser_en_n |=> ($stable(x_ofs) && $stable(y_ofs)));

  // R5
  p_done_count_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(prog_done) && serial_c) |-> (taken_c == CNT_W'(TOTAL_BITS)));

  // R5
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    prog_done |=> prog_done);

  // R6
  p_ready_gated_r6: assert property (@(posedge clk) disable iff (rst)
    (serial_c && in_ready) |-> $past(prog_done));

  // R7
  p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (serial_c && prog_done) |=> ($stable(x_ofs) && $stable(y_ofs)));

  // R8
  p_default_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (!serial_c && !$past(rst)) |-> (in_ready && prog_done && x_ofs == DEF && y_ofs == DEF));
endmodule

bind serial_offset_loader serial_offset_loader_chk #(
  .OFS_W(OFS_W), .DEFAULT_OFS(DEFAULT_OFS)
) u_chk (.*);

// File: tb/tb_serial_offset_loader.sv
`timescale 1ns/1ps
module tb_serial_offset_loader;
  localparam int W = 9;

  typedef struct {
    string      tag;
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic       rdy;
    logic       done;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_data = 1'b0;
  logic ser_en_n = 1'b1;
  logic [W-1:0] x_ofs, y_ofs;
  logic in_ready, prog_done;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  exp_t sb[$];

  // bench reference state
  logic         m_serial = 1'b0;
  int           m_cnt = 0;
  logic [2*W-1:0] m_chain = {9'd8, 9'd8};
  logic         m_done = 1'b0;
  logic         m_rdy = 1'b0;

  always #10 clk = ~clk;

  serial_offset_loader dut (
    .clk(clk), .rst(rst), .ser_data(ser_data), .ser_en_n(ser_en_n),
    .x_ofs(x_ofs), .y_ofs(y_ofs), .in_ready(in_ready), .prog_done(prog_done)
  );

  // Driver: apply one cycle of stimulus and push the predicted result.
  task automatic step(input logic r, input logic sd, input logic en_n, input string tag);
    exp_t e;
    logic old_done;
    @(negedge clk);
    rst = r; ser_data = sd; ser_en_n = en_n;
    @(posedge clk);
    #1;
    if (r) begin
      m_serial = sd && en_n;
      m_cnt = 0;
      m_chain = {9'd8, 9'd8};
      m_done = 1'b0;
      m_rdy = 1'b0;
    end else if (!m_serial) begin
      m_done = 1'b1;
      m_rdy = 1'b1;
    end else begin
      old_done = m_done;
      if (!en_n && m_cnt < 2*W) begin
        m_chain = {m_chain[2*W-2:0], sd};
        m_cnt++;
        if (m_cnt == 2*W) m_done = 1'b1;
      end
      m_rdy = old_done;
    end
    e.tag = tag; e.x = m_chain[W-1:0]; e.y = m_chain[2*W-1:W];
    e.rdy = m_rdy; e.done = m_done;
    sb.push_back(e);
  endtask

  // Monitor: compare between edges.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (x_ofs !== e.x || y_ofs !== e.y || in_ready !== e.rdy || prog_done !== e.done) begin
        bad++;
        $display("FAIL %s: got x=%0d y=%0d rdy=%b done=%b, expected x=%0d y=%0d rdy=%b done=%b",
                 e.tag, x_ofs, y_ofs, in_ready, prog_done, e.x, e.y, e.rdy, e.done);
      end
    end
  end

  task automatic serial_reset(input string tag);
    step(1'b1, 1'b1, 1'b1, tag);
    step(1'b1, 1'b1, 1'b1, tag);
  endtask

  task automatic load(input logic [W-1:0] yv, input logic [W-1:0] xv, input bit gaps);
    logic [2*W-1:0] word;
    word = {yv, xv};
    for (int i = 2*W-1; i >= 0; i--) begin
      if (gaps && (i % 3 == 0)) step(1'b0, ~word[i], 1'b1, "R3");
      step(1'b0, word[i], 1'b0, (i == 0) ? "R5" : "R4");
    end
    step(1'b0, 1'b0, 1'b1, "R6");
  endtask

  initial begin
    // R1 reset state; R2 serial selection
    serial_reset("R1");
    load(9'd300, 9'd5, 1'b1);
    // R7 strobes after completion
    for (int k = 0; k < 4; k++) step(1'b0, k[0], 1'b0, "R7");

    // R2/R8 default mode with ser_data low
    step(1'b1, 1'b0, 1'b1, "R1");
    step(1'b1, 1'b0, 1'b1, "R2");
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1, 1'b0, "R8");

    // R2/R8 default mode with ser_en_n low
    step(1'b1, 1'b1, 1'b0, "R2");
    for (int k = 0; k < 3; k++) step(1'b0, ~k[0], 1'b0, "R8");

    // R9 reset part way through a sequence
    serial_reset("R2");
    for (int k = 0; k < 7; k++) step(1'b0, 1'b1, 1'b0, "R4");
    serial_reset("R9");
    load(9'd1, 9'd508, 1'b0);
    step(1'b0, 1'b1, 1'b0, "R7");

    serial_reset("R1");
    load(9'd508, 9'd1, 1'b1);
    step(1'b0, 1'b0, 1'b0, "R7");

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule